// File: doc/BRIEF.md
# DRAM Low-Power Entry Sequencer

This block decides when a DRAM controller moves its memory rank into power-down or self-refresh, and it drives the signals that go with each low-power state. It watches an idle flag from the request bus, a count of outstanding requests, a two-bit power-status level and a flag that reports all DRAM timing rules as met. From these it requests the commands the command path must issue: precharge-all, power-down entry, self-refresh entry and self-refresh exit. Each request is held until the command path acknowledges it.

The block also sets the CKE level, a tristate enable for the clock pair, and request lines for the core and PHY clock trees. A small configuration register chooses which features take part. Software writes it through a one-cycle write strobe, and writes are allowed while traffic runs. Any new traffic wakes the rank again. Clocks are restored and CKE is raised before the scheduler-ready output returns.

Top module: `dram_lp_sequencer`

## Requirements
- R1: The configuration register has seven bits. Bit 0 enables automatic self-refresh. Bit 1 blocks power-down. Bit 2 requests precharge-all before power-down entry. Bit 3 enables core clock gating. Bit 4 enables PHY clock gating. Bit 5 enables the clock tristate. Bit 6 selects low-power DRAM mode. Reset loads 7'b0000010. After reset, with the bus idle, CKE therefore stays 1, no command is requested, both clock requests are 1 and the scheduler-ready output is 1.
- R2: While bit 1 is 1, CKE is 1 in every cycle and no power-down or self-refresh entry is requested. Setting the bit while the rank is in power-down or self-refresh raises CKE in the same cycle, and the block then returns to the active state (through a self-refresh exit request if it was in self-refresh).
- R3: With bit 1 clear, a bus that is idle, no pending requests and timing met, the block requests power-down entry. On acknowledge, CKE goes to 0 on the next cycle. If timing is not met, nothing is requested.
- R4: With bit 2 set, a precharge-all request is made first and held until acknowledged. The power-down entry request follows only after that acknowledge.
- R5: A delay counter reloads from the programmed delay while the bus is busy or requests are pending, and counts down once per cycle while both are quiet. Self-refresh entry is requested exactly one cycle after the count reaches zero, and only when bit 0 is set, the power status is below 2 and timing is met.
- R6: In self-refresh, the core clock request is 0 if bit 3 is set and the PHY clock request is 0 if bit 4 is set. Otherwise each request is 1, and both are 1 in every other state.
- R7: The clock tristate output is 1 only in power-down with bits 5 and 6 both set.
- R8: Bus activity or a pending request ends power-down on the next cycle and ends self-refresh through a self-refresh exit request. During that exit request CKE is 1 and both clock requests are 1. Scheduler-ready is 1 only in the active state.
- R9: At most one command request output is 1 in any cycle.
- R10: Bit 0 may be changed at run time. Clearing it stops a pending self-refresh entry, and setting it again starts the entry once the other conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| bus_idle | input | 1 | Request bus idle |
| pend_cnt | input | PEND_W | Outstanding request count |
| pwr_status | input | PSTAT_W | Power-status level |
| timing_ok | input | 1 | DRAM timing requirements met |
| sr_delay | input | DLY_W | Self-refresh idle delay reload value |
| prea_ack | input | 1 | Precharge-all accepted |
| pde_ack | input | 1 | Power-down entry accepted |
| sre_ack | input | 1 | Self-refresh entry accepted |
| srx_ack | input | 1 | Self-refresh exit accepted |
| prea_req | output | 1 | Precharge-all request |
| pde_req | output | 1 | Power-down entry request |
| sre_req | output | 1 | Self-refresh entry request |
| srx_req | output | 1 | Self-refresh exit request |
| cke | output | 1 | CKE level |
| ck_tristate | output | 1 | Clock pair tristate enable |
| core_clk_req | output | 1 | Core clock tree request |
| phy_clk_req | output | 1 | PHY clock tree request |
| sched_ready | output | 1 | Scheduler may issue commands |

## Verification
Power-down entry and expiry of the self-refresh delay can coincide. The bench starts the idle period so that power-down is taken on the first cycle while the counter still runs, for delays of 1 to 4 cycles. This includes a delay of 1, where the count expires in the same cycle that power-down is entered. For each delay it checks that the self-refresh request appears exactly one cycle after expiry, straight from power-down. A second clash is a configuration write landing while the rank is in a low-power state. Setting the power-down block bit in self-refresh must raise CKE in that same cycle, and re-enabling self-refresh must start entry one cycle after the write.

// File: rtl/dlp_pkg.sv
// Package: shared state encoding and configuration layout for the
// DRAM low-power entry sequencer.
package dlp_pkg;

    localparam int CFG_W = 7;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_ACTIVE       = 3'd0,
        ST_PRECHARGE    = 3'd1,
        ST_POWERDOWN    = 3'd2,
        ST_SR_ENTRY     = 3'd3,
        ST_SELF_REFRESH = 3'd4,
        ST_SR_EXIT      = 3'd5
    } lp_state_t;

    // Configuration fields; the last member sits at bit 0.
    typedef struct packed {
        logic lp_mode;       // bit 6
        logic ck_tri_en;     // bit 5
        logic phy_gate_en;   // bit 4
        logic core_gate_en;  // bit 3
        logic prea_en;       // bit 2
        logic pd_block;      // bit 1
        logic dyn_sr_en;     // bit 0
    } lp_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 7'b0000010;

endpackage

// File: rtl/dlp_cfg_reg.sv
// Module: dlp_cfg_reg
// Holds the configuration word. Assumes writes are single-cycle strobes
// and may arrive in any sequencer state.
module dlp_cfg_reg
    import dlp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output lp_cfg_t          cfg
);

    // Capture the configuration on a write strobe; reset blocks power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= lp_cfg_t'(CFG_RESET);
        else if (we)
            cfg <= lp_cfg_t'(wdata);
    end

endmodule

// File: rtl/dlp_idle_timer.sv
// Module: dlp_idle_timer
// Self-refresh delay counter. Reloads from the programmed delay while the
// bus is busy or requests are pending, counts down while quiet, and flags
// expiry at zero. Assumes the reload value is stable during a quiet period.
module dlp_idle_timer #(
    parameter int DLY_W  = 8,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_idle,
    input  logic [PEND_W-1:0] pend_cnt,
    input  logic [DLY_W-1:0]  reload_val,
    output logic              expired
);

    logic [DLY_W-1:0] cnt;
    logic             quiet;

    assign quiet   = bus_idle && (pend_cnt == '0);
    assign expired = (cnt == '0);

    // Reload on activity, count down to zero while quiet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (!quiet)
            cnt <= reload_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // R5: any activity leaves the counter at the programmed delay.
    a_r5_reload_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (cnt == $past(reload_val)));

    // R5: while quiet the counter never rises.
    a_r5_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && $past(quiet) && $past(rst_n)) |-> (cnt <= $past(cnt)));

endmodule

// File: rtl/dlp_fsm.sv
// Module: dlp_fsm
// Low-power state machine. Chooses power-down or self-refresh entry from
// the idle conditions and raises one held command request at a time.
// Assumes each acknowledge is sampled only while its request is high.
module dlp_fsm #(
    parameter int PEND_W  = 4,
    parameter int PSTAT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dlp_pkg::lp_cfg_t   cfg,
    input  logic               bus_idle,
    input  logic [PEND_W-1:0]  pend_cnt,
    input  logic [PSTAT_W-1:0] pwr_status,
    input  logic               timing_ok,
    input  logic               expired,
    input  logic               prea_ack,
    input  logic               pde_ack,
    input  logic               sre_ack,
    input  logic               srx_ack,
    output logic               prea_req,
    output logic               pde_req,
    output logic               sre_req,
    output logic               srx_req,
    output dlp_pkg::lp_state_t state
);
    import dlp_pkg::*;

    localparam logic [PSTAT_W-1:0] PSTAT_LIMIT = PSTAT_W'(2);

    lp_state_t nxt;
    logic      idle_ok, wake, pd_go, sr_go, prea_done;

    assign idle_ok = bus_idle && (pend_cnt == '0);
    assign wake    = !idle_ok || cfg.pd_block;
    assign pd_go   = idle_ok && timing_ok && !cfg.pd_block;
    assign sr_go   = pd_go && cfg.dyn_sr_en && (pwr_status < PSTAT_LIMIT) && expired;

    // Command requests decoded from the state and live conditions.
    always_comb begin
        prea_req = (state == ST_PRECHARGE);
        pde_req  = (state == ST_ACTIVE) && pd_go && !sr_go &&
                   (!cfg.prea_en || prea_done);
        sre_req  = (state == ST_SR_ENTRY) && !wake;
        srx_req  = (state == ST_SR_EXIT);
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (sr_go)
                    nxt = ST_SR_ENTRY;
                else if (pd_go && cfg.prea_en && !prea_done)
                    nxt = ST_PRECHARGE;
                else if (pde_req && pde_ack)
                    nxt = ST_POWERDOWN;
            end
            ST_PRECHARGE:    if (prea_ack) nxt = ST_ACTIVE;
            ST_POWERDOWN: begin
                if (wake)
                    nxt = ST_ACTIVE;
                else if (sr_go)
                    nxt = ST_SR_ENTRY;
            end
            ST_SR_ENTRY: begin
                if (wake)
                    nxt = ST_ACTIVE;
                else if (sre_ack)
                    nxt = ST_SELF_REFRESH;
            end
            ST_SELF_REFRESH: if (wake) nxt = ST_SR_EXIT;
            ST_SR_EXIT:      if (srx_ack) nxt = ST_ACTIVE;
            default:         nxt = ST_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ACTIVE;
        else
            state <= nxt;
    end

    // Remember a completed precharge-all until power-down or activity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prea_done <= 1'b0;
        else if (prea_req && prea_ack)
            prea_done <= 1'b1;
        else if ((state == ST_POWERDOWN) || !idle_ok)
            prea_done <= 1'b0;
    end

    // R9: never two command requests together.
    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prea_req, pde_req, sre_req, srx_req}));

    // R5: self-refresh entry only after the delay counter has expired.
    a_r5_sre_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        sre_req |-> expired);

    // R2: no low-power entry request while power-down is blocked.
    a_r2_no_entry_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.pd_block |-> !(pde_req || sre_req));

    // R8: self-refresh is left only through the exit state.
    a_r8_sr_exit_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELF_REFRESH) |=> (state == ST_SELF_REFRESH || state == ST_SR_EXIT));

endmodule

// File: rtl/dlp_side_out.sv
// Module: dlp_side_out
// Decodes CKE, clock tristate, clock-tree requests and scheduler-ready
// from the state and configuration. Purely combinational.
module dlp_side_out (
    input  dlp_pkg::lp_state_t state,
    input  dlp_pkg::lp_cfg_t   cfg,
    output logic               cke,
    output logic               ck_tristate,
    output logic               core_clk_req,
    output logic               phy_clk_req,
    output logic               sched_ready
);
    import dlp_pkg::*;

    logic in_sr;

    // Side-signal decode for the current state.
    always_comb begin
        in_sr        = (state == ST_SELF_REFRESH);
        cke          = cfg.pd_block || !((state == ST_POWERDOWN) || in_sr);
        ck_tristate  = (state == ST_POWERDOWN) && cfg.ck_tri_en &&
                       cfg.lp_mode && !cfg.pd_block;
        core_clk_req = !(in_sr && cfg.core_gate_en);
        phy_clk_req  = !(in_sr && cfg.phy_gate_en);
        sched_ready  = (state == ST_ACTIVE);
    end

endmodule

// File: rtl/dram_lp_sequencer.sv
// Module: dram_lp_sequencer (top)
// Joins configuration register, idle timer, state machine and output
// decode. Assumes command acknowledges come from the command path and
// that inputs are synchronous to clk.
module dram_lp_sequencer #(
    parameter int DLY_W   = 8,
    parameter int PEND_W  = 4,
    parameter int PSTAT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [6:0]         cfg_wdata,
    input  logic               bus_idle,
    input  logic [PEND_W-1:0]  pend_cnt,
    input  logic [PSTAT_W-1:0] pwr_status,
    input  logic               timing_ok,
    input  logic [DLY_W-1:0]   sr_delay,
    input  logic               prea_ack,
    input  logic               pde_ack,
    input  logic               sre_ack,
    input  logic               srx_ack,
    output logic               prea_req,
    output logic               pde_req,
    output logic               sre_req,
    output logic               srx_req,
    output logic               cke,
    output logic               ck_tristate,
    output logic               core_clk_req,
    output logic               phy_clk_req,
    output logic               sched_ready
);
    import dlp_pkg::*;

    lp_cfg_t   cfg;
    lp_state_t state;
    logic      expired;

    dlp_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dlp_idle_timer #(.DLY_W(DLY_W), .PEND_W(PEND_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_idle   (bus_idle),
        .pend_cnt   (pend_cnt),
        .reload_val (sr_delay),
        .expired    (expired)
    );

    dlp_fsm #(.PEND_W(PEND_W), .PSTAT_W(PSTAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .bus_idle   (bus_idle),
        .pend_cnt   (pend_cnt),
        .pwr_status (pwr_status),
        .timing_ok  (timing_ok),
        .expired    (expired),
        .prea_ack   (prea_ack),
        .pde_ack    (pde_ack),
        .sre_ack    (sre_ack),
        .srx_ack    (srx_ack),
        .prea_req   (prea_req),
        .pde_req    (pde_req),
        .sre_req    (sre_req),
        .srx_req    (srx_req),
        .state      (state)
    );

    dlp_side_out u_side (
        .state        (state),
        .cfg          (cfg),
        .cke          (cke),
        .ck_tristate  (ck_tristate),
        .core_clk_req (core_clk_req),
        .phy_clk_req  (phy_clk_req),
        .sched_ready  (sched_ready)
    );

    // R2: CKE can only fall after a cycle with power-down unblocked.
    a_r2_no_cke_fall_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(cfg.pd_block));

    // R8: ready implies clocks running and CKE high.
    a_r8_ready_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
        sched_ready |-> (cke && core_clk_req && phy_clk_req));

    // R7: clock tristate only while CKE is low.
    a_r7_tristate_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        ck_tristate |-> !cke);

    // R6: clock trees gated only when the scheduler is not ready.
    a_r6_gate_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_req || !phy_clk_req) |-> !sched_ready);

endmodule

// File: tb/sim_dram_lp_sequencer.sv
// Self-checking bench for dram_lp_sequencer.
module sim_dram_lp_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [6:0] cfg_wdata;
    logic       bus_idle;
    logic [3:0] pend_cnt;
    logic [1:0] pwr_status;
    logic       timing_ok;
    logic [7:0] sr_delay;
    logic       prea_ack, pde_ack, sre_ack, srx_ack;
    logic       prea_req, pde_req, sre_req, srx_req;
    logic       cke, ck_tristate, core_clk_req, phy_clk_req, sched_ready;

    int checks = 0;
    int errors = 0;
    int multi_req = 0;

    always #4 clk = ~clk;

    dram_lp_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_idle(bus_idle), .pend_cnt(pend_cnt), .pwr_status(pwr_status),
        .timing_ok(timing_ok), .sr_delay(sr_delay),
        .prea_ack(prea_ack), .pde_ack(pde_ack), .sre_ack(sre_ack), .srx_ack(srx_ack),
        .prea_req(prea_req), .pde_req(pde_req), .sre_req(sre_req), .srx_req(srx_req),
        .cke(cke), .ck_tristate(ck_tristate), .core_clk_req(core_clk_req),
        .phy_clk_req(phy_clk_req), .sched_ready(sched_ready)
    );

    // Configuration word: {lp, tri, phy, core, prea, pd_block, dyn}.
    function automatic logic [6:0] mk(input bit lp, tri_e, phy, core, prea, blk, dyn);
        return {lp, tri_e, phy, core, prea, blk, dyn};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance n rising edges and land on the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [6:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // R9 monitor: count samples with more than one request.
    always @(negedge clk)
        if (rst_n && ($countones({prea_req, pde_req, sre_req, srx_req}) > 1))
            multi_req++;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        bus_idle = 1'b1; pend_cnt = '0; pwr_status = '0; timing_ok = 1'b1;
        sr_delay = 8'd200;
        prea_ack = 1'b0; pde_ack = 1'b0; sre_ack = 1'b0; srx_ack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(20);
        // R1: reset configuration blocks power-down, features off.
        chk("R1", "cke", cke, 1);
        chk("R1", "pde_req", pde_req, 0);
        chk("R1", "sre_req", sre_req, 0);
        chk("R1", "core_clk_req", core_clk_req, 1);
        chk("R1", "phy_clk_req", phy_clk_req, 1);
        chk("R1", "sched_ready", sched_ready, 1);

        // R3: unblock power-down while idle.
        wr_cfg(mk(0,0,0,0,0,0,0));
        chk("R3", "pde_req", pde_req, 1);
        chk("R3", "prea_req", prea_req, 0);
        pde_ack = 1'b1;
        tick(1);
        pde_ack = 1'b0;
        chk("R3", "cke in power-down", cke, 0);
        chk("R8", "ready in power-down", sched_ready, 0);
        // R8: activity ends power-down on the next cycle.
        bus_idle = 1'b0;
        tick(1);
        chk("R8", "cke after wake", cke, 1);
        chk("R8", "ready after wake", sched_ready, 1);

        // R3: timing not met blocks entry.
        timing_ok = 1'b0;
        bus_idle = 1'b1;
        tick(6);
        chk("R3", "pde_req timing low", pde_req, 0);
        chk("R3", "cke timing low", cke, 1);
        bus_idle = 1'b0;
        timing_ok = 1'b1;
        tick(1);

        // R4: precharge-all first, held until acknowledged.
        wr_cfg(mk(0,0,0,0,1,0,0));
        pde_ack = 1'b1;
        bus_idle = 1'b1;
        tick(1);
        chk("R4", "prea_req", prea_req, 1);
        chk("R4", "pde_req before prea ack", pde_req, 0);
        tick(3);
        chk("R4", "prea_req held", prea_req, 1);
        chk("R4", "pde_req still low", pde_req, 0);
        prea_ack = 1'b1;
        tick(1);
        prea_ack = 1'b0;
        chk("R4", "pde_req after prea", pde_req, 1);
        chk("R4", "prea_req dropped", prea_req, 0);
        tick(1);
        chk("R4", "cke after pde", cke, 0);

        // R7: tristate sweep over enable and mode bits.
        for (int k = 0; k < 4; k++) begin
            bus_idle = 1'b0;
            tick(1);
            wr_cfg(mk(k[1], k[0], 0, 0, 0, 0, 0));
            chk("R7", "tristate active", ck_tristate, 0);
            bus_idle = 1'b1;
            tick(1);
            chk("R7", "cke", cke, 0);
            chk("R7", "tristate in power-down", ck_tristate, int'(k == 3));
        end

        // R5/R6: self-refresh delay sweep with gating variants.
        pde_ack = 1'b1;
        for (int d = 1; d <= 4; d++) begin
            bus_idle = 1'b0;
            sr_delay = 8'(d);
            wr_cfg(mk(0, 0, d[1], d[0], 0, 0, 1));
            tick(1);
            bus_idle = 1'b1;
            tick(d);
            chk("R5", "sre_req at expiry", sre_req, 0);
            chk("R5", "cke in power-down", cke, 0);
            tick(1);
            chk("R5", "sre_req one cycle later", sre_req, 1);
            sre_ack = 1'b1;
            tick(1);
            sre_ack = 1'b0;
            chk("R6", "cke in self-refresh", cke, 0);
            chk("R6", "core_clk_req", core_clk_req, int'(d[0] == 1'b0));
            chk("R6", "phy_clk_req", phy_clk_req, int'(d[1] == 1'b0));
            tick(3);
            chk("R8", "ready in self-refresh", sched_ready, 0);
            pend_cnt = 4'd1;
            tick(1);
            chk("R8", "srx_req", srx_req, 1);
            chk("R8", "cke on exit", cke, 1);
            chk("R8", "core clk on exit", core_clk_req, 1);
            chk("R8", "phy clk on exit", phy_clk_req, 1);
            chk("R8", "ready during exit", sched_ready, 0);
            srx_ack = 1'b1;
            tick(1);
            srx_ack = 1'b0;
            chk("R8", "ready after exit", sched_ready, 1);
            chk("R8", "srx_req cleared", srx_req, 0);
            pend_cnt = 4'd0;
        end

        // R5: power status sweep.
        sr_delay = 8'd2;
        for (int p = 0; p < 4; p++) begin
            bus_idle = 1'b0;
            pwr_status = 2'(p);
            wr_cfg(mk(0,0,0,0,0,0,1));
            tick(1);
            bus_idle = 1'b1;
            tick(6);
            chk("R5", "sre_req vs power status", sre_req, int'(p < 2));
        end
        bus_idle = 1'b0;
        pwr_status = '0;
        tick(1);

        // R10: clearing and setting the enable at run time.
        sr_delay = 8'd6;
        tick(1);
        bus_idle = 1'b1;
        tick(3);
        wr_cfg(mk(0,0,0,0,0,0,0));
        tick(8);
        chk("R10", "sre_req while disabled", sre_req, 0);
        chk("R10", "cke still power-down", cke, 0);
        wr_cfg(mk(0,0,0,0,0,0,1));
        chk("R10", "sre_req on write edge", sre_req, 0);
        tick(1);
        chk("R10", "sre_req after re-enable", sre_req, 1);
        sre_ack = 1'b1;
        tick(1);
        sre_ack = 1'b0;
        chk("R10", "in self-refresh", cke, 0);

        // R2: blocking power-down while in self-refresh.
        wr_cfg(mk(0,0,0,0,0,1,1));
        chk("R2", "cke same cycle", cke, 1);
        tick(1);
        chk("R2", "srx_req", srx_req, 1);
        srx_ack = 1'b1;
        tick(1);
        srx_ack = 1'b0;
        chk("R2", "ready", sched_ready, 1);
        tick(10);
        chk("R2", "pde_req blocked", pde_req, 0);
        chk("R2", "sre_req blocked", sre_req, 0);
        chk("R2", "cke held", cke, 1);

        // R9: single request per cycle over the whole run.
        chk("R9", "multi-request samples", multi_req, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule